// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers interrupt requests from five sources and turns them into vectored call requests for a small CPU core. The sources are an external pin, two timer overflows, an A/D conversion-complete event and a time-base overflow. Each source has a latched request flag and its own enable bit. One global enable masks all of them. The external pin goes through an edge detector that can be set to rising, falling, both or no edges.

Arbitration happens only on the rising edge of a periodic phase strobe, so requests that arrive between two strobe edges are all considered together at the later one. When the global enable is set, the stack is not full and no call is still waiting, the block picks the enabled pending source of highest priority. It then pulses a call request together with that source's fixed vector address. The CPU acknowledges the call. In the acknowledge cycle the winning flag and the global enable are cleared. Software reads the flags and enables on dedicated outputs and changes them through a simple register write port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all flags, all enables and the global enable are 0, `call_req` is 0 and `call_vec` is 0x00.
- R2: A one-cycle pulse on `hw_evt[k]` sets flag k+1 at the next clock edge. The external pin sets flag 0 on the edge chosen by `ext_edge_mode`: 00 no edge, 01 rising, 10 falling, 11 both. The pin is compared against its value one cycle earlier.
- R3: Arbitration happens only in the cycle in which `phase_strobe` is high and was low in the previous cycle. A flag that becomes visible in that same cycle or later waits for the next such rise. A held-high strobe gives only one arbitration. `call_req` rises the cycle after the strobe rise.
- R4: Priority is fixed, from highest to lowest: flag 0 (external), flag 1 (timer 0), flag 2 (timer 1), flag 3 (A/D), flag 4 (time base).
- R5: The vector for flag i is 4*(i+1): 0x04, 0x08, 0x0C, 0x10 and 0x14. `call_vec` holds the vector until the call is acknowledged.
- R6: A call is issued only when the global enable is 1 and the winning flag's own enable is 1. A masked flag stays latched and is served at a later strobe rise once it is enabled.
- R7: No call is issued at a strobe rise while `stack_full` is 1.
- R8: `call_req` is high for exactly one cycle. No further call is issued until `call_ack` is seen. `call_ack` with no call outstanding is ignored.
- R9: When `call_ack` is seen, the winning flag and the global enable read 0 from the next cycle on. All other flags are unchanged.
- R10: With `reg_we`=1, address 0 writes the five flags, address 1 writes the five enables and address 2 writes the global enable from data bit 0. Address 3 changes nothing. In the same cycle, an acknowledge clear is applied after the software write.
- R11: A hardware event that sets a flag wins over a software clear or an acknowledge clear of that flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | External interrupt pin (synchronous) |
| ext_edge_mode | input | 2 | Pin edge select: 00 off, 01 rise, 10 fall, 11 both |
| hw_evt | input | 4 | Internal event pulses: timer 0, timer 1, A/D, time base |
| phase_strobe | input | 1 | Service phase strobe; its rising edge triggers arbitration |
| stack_full | input | 1 | CPU stack full, blocks new calls |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register select: 0 flags, 1 enables, 2 global enable |
| reg_wdata | input | 5 | Register write data |
| call_ack | input | 1 | CPU acknowledges the outstanding call |
| call_req | output | 1 | One-cycle call request |
| call_vec | output | 8 | Vector address of the call |
| flag_o | output | 5 | Request flags |
| enable_o | output | 5 | Per-source enables |
| gie_o | output | 1 | Global enable |

## Verification
The assertions check the following on every cycle:
- `call_req` lasts exactly one cycle.
- A call only follows a strobe rise with the global enable set, an eligible flag and the stack not full.
- The vector is one of the five legal values and stays stable while a call is outstanding.
- An acknowledge clears the global enable and the winning flag.
- A hardware set always lands.

Only the bench scenarios can show that the fixed priority order gives the right vector sequence when all five sources are pending. The same holds for the external pin's four edge modes, masked flags surviving until they are enabled, and an event that coincides with the strobe rise being deferred to the next rise.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int VEC_W    = 8;
  localparam int VEC_STEP = 4;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam logic [1:0] ADDR_FLAGS   = 2'd0;
  localparam logic [1:0] ADDR_ENABLES = 2'd1;
  localparam logic [1:0] ADDR_GIE     = 2'd2;

  // Vector of source idx: one step per source, starting one step above zero.
  function automatic logic [VEC_W-1:0] vector_of(input int idx);
    return VEC_W'((idx + 1) * VEC_STEP);
  endfunction

  // Does a pin transition match the selected edge mode?
  function automatic logic edge_hit(input logic now_v, input logic prev_v,
                                    input edge_mode_e mode);
    logic rise_v;
    logic fall_v;
    rise_v = now_v & ~prev_v;
    fall_v = ~now_v & prev_v;
    case (mode)
      EDGE_RISE: return rise_v;
      EDGE_FALL: return fall_v;
      EDGE_BOTH: return rise_v | fall_v;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/irq_edge_unit.sv
module irq_edge_unit
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] mode,
  input  logic       strobe,
  output logic       pin_evt,
  output logic       strobe_rise
);

  logic pin_d;
  logic strobe_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_d    <= 1'b0;
      strobe_d <= 1'b0;
    end else begin
      pin_d    <= pin;
      strobe_d <= strobe;
    end
  end

  assign pin_evt     = edge_hit(pin, pin_d, edge_mode_e'(mode));
  assign strobe_rise = strobe & ~strobe_d;

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] ack_clr_vec,
  input  logic               ack_clr_gie,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [NUM_SRC-1:0] wr_data,
  output logic [NUM_SRC-1:0] flag_q,
  output logic [NUM_SRC-1:0] en_q,
  output logic               gie_q
);

  logic wr_flags;
  logic wr_en_reg;
  logic wr_gie;

  assign wr_flags  = wr_en && (wr_addr == ADDR_FLAGS);
  assign wr_en_reg = wr_en && (wr_addr == ADDR_ENABLES);
  assign wr_gie    = wr_en && (wr_addr == ADDR_GIE);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic base_v;
    always_comb begin
      base_v = wr_flags ? wr_data[i] : flag_q[i];
      if (ack_clr_vec[i]) base_v = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
      end else begin
        flag_q[i] <= base_v | set_vec[i];
        if (wr_en_reg) en_q[i] <= wr_data[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
    end else if (ack_clr_gie) begin
      gie_q <= 1'b0;
    end else if (wr_gie) begin
      gie_q <= wr_data[0];
    end
  end

endmodule

// File: rtl/irq_priority_pick.sv
module irq_priority_pick #(
  parameter int NUM_SRC = 5,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req_vec,
  output logic [NUM_SRC-1:0] win_oh,
  output logic [IDX_W-1:0]   win_idx,
  output logic               any_req
);

  // Lowest index is the highest priority: scan from the top so it wins last.
  always_comb begin
    win_oh  = '0;
    win_idx = '0;
    any_req = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        win_oh    = '0;
        win_oh[i] = 1'b1;
        win_idx   = IDX_W'(i);
        any_req   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_pin,
  input  logic [1:0]         ext_edge_mode,
  input  logic [NUM_SRC-2:0] hw_evt,
  input  logic               phase_strobe,
  input  logic               stack_full,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  input  logic               call_ack,
  output logic               call_req,
  output logic [VEC_W-1:0]   call_vec,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [NUM_SRC-1:0] enable_o,
  output logic               gie_o
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  // Named internal events
  logic               ext_evt;
  logic               strobe_rise;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] eligible;
  logic [NUM_SRC-1:0] win_oh;
  logic [IDX_W-1:0]   win_idx;
  logic               any_req;
  logic               issue;
  logic               ack_take;
  logic               pending;
  logic [NUM_SRC-1:0] win_oh_q;
  logic [NUM_SRC-1:0] ack_clr_vec;

  irq_edge_unit u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin         (ext_pin),
    .mode        (ext_edge_mode),
    .strobe      (phase_strobe),
    .pin_evt     (ext_evt),
    .strobe_rise (strobe_rise)
  );

  assign set_vec     = {hw_evt, ext_evt};
  assign ack_take    = pending & call_ack;
  assign ack_clr_vec = ack_take ? win_oh_q : '0;

  irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_vec     (set_vec),
    .ack_clr_vec (ack_clr_vec),
    .ack_clr_gie (ack_take),
    .wr_en       (reg_we),
    .wr_addr     (reg_addr),
    .wr_data     (reg_wdata),
    .flag_q      (flag_o),
    .en_q        (enable_o),
    .gie_q       (gie_o)
  );

  assign eligible = flag_o & enable_o;

  irq_priority_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .req_vec (eligible),
    .win_oh  (win_oh),
    .win_idx (win_idx),
    .any_req (any_req)
  );

  assign issue = strobe_rise & gie_o & ~stack_full & ~pending & any_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      call_req <= 1'b0;
      call_vec <= '0;
      win_oh_q <= '0;
    end else begin
      call_req <= issue;
      if (issue) begin
        pending  <= 1'b1;
        call_vec <= vector_of(int'(win_idx));
        win_oh_q <= win_oh;
      end else if (ack_take) begin
        pending  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NUM_SRC = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               call_req,
  input logic [7:0]         call_vec,
  input logic               call_ack,
  input logic               stack_full,
  input logic               strobe_rise,
  input logic               pending,
  input logic [NUM_SRC-1:0] flag_o,
  input logic [NUM_SRC-1:0] enable_o,
  input logic               gie_o,
  input logic [NUM_SRC-1:0] set_vec,
  input logic [NUM_SRC-1:0] win_oh_q
);

  assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> !call_req);

  assert_req_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(strobe_rise));

  assert_stack_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !$past(stack_full));

  assert_enables_needed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> ($past(gie_o) && ($past(flag_o & enable_o) != '0)));

  assert_vec_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (call_vec[1:0] == 2'b00 && call_vec >= 8'd4
                  && call_vec <= 8'(4 * NUM_SRC)));

  assert_vec_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && $past(pending)) |-> $stable(call_vec));

  assert_winner_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> $onehot(win_oh_q));

  assert_ack_clears_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && call_ack) |=> !gie_o);

  assert_ack_clears_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && call_ack && ((set_vec & win_oh_q) == '0))
      |=> ((flag_o & $past(win_oh_q)) == '0));

  assert_hw_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flag_o & $past(set_vec)) == $past(set_vec)));

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .call_req    (call_req),
  .call_vec    (call_vec),
  .call_ack    (call_ack),
  .stack_full  (stack_full),
  .strobe_rise (strobe_rise),
  .pending     (pending),
  .flag_o      (flag_o),
  .enable_o    (enable_o),
  .gie_o       (gie_o),
  .set_vec     (set_vec),
  .win_oh_q    (win_oh_q)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_pin = 1'b0;
  logic [1:0] ext_edge_mode = 2'b00;
  logic [3:0] hw_evt = '0;
  logic       phase_strobe = 1'b0;
  logic       stack_full = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [4:0] reg_wdata = '0;
  logic       call_ack = 1'b0;
  logic       call_req;
  logic [7:0] call_vec;
  logic [4:0] flag_o;
  logic [4:0] enable_o;
  logic       gie_o;

  always #2 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_edge_mode(ext_edge_mode),
    .hw_evt(hw_evt), .phase_strobe(phase_strobe), .stack_full(stack_full),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .call_ack(call_ack), .call_req(call_req), .call_vec(call_vec),
    .flag_o(flag_o), .enable_o(enable_o), .gie_o(gie_o)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_tag  = "R1";

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit       m_sd, m_pd, m_pend, m_req, m_gie;
  int       m_win;
  int       m_vec;
  bit [4:0] m_flag, m_en;
  bit       t_rise, t_ext, t_ack, t_found;
  bit [4:0] t_set, t_flag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sd = 0; m_pd = 0; m_pend = 0; m_req = 0; m_gie = 0;
      m_win = 0; m_vec = 0; m_flag = 0; m_en = 0;
    end else begin
      t_rise = phase_strobe && !m_sd;
      case (ext_edge_mode)
        2'b01:   t_ext = ext_pin && !m_pd;
        2'b10:   t_ext = !ext_pin && m_pd;
        2'b11:   t_ext = ext_pin != m_pd;
        default: t_ext = 0;
      endcase
      t_set = {hw_evt, t_ext};
      t_ack = m_pend && call_ack;
      t_flag = m_flag;
      m_req = 0;
      t_found = 0;
      if (t_rise && !m_pend && m_gie && !stack_full) begin
        for (int w = 0; w < 5; w++) begin
          if (!t_found && m_flag[w] && m_en[w]) begin
            t_found = 1; m_win = w; m_vec = (w + 1) * 4;
          end
        end
      end
      if (reg_we && reg_addr == 2'd0) t_flag = reg_wdata;
      if (reg_we && reg_addr == 2'd1) m_en = reg_wdata;
      if (reg_we && reg_addr == 2'd2) m_gie = reg_wdata[0];
      if (t_ack) begin
        t_flag[m_win] = 0;
        m_gie = 0;
        m_pend = 0;
      end
      if (t_found) begin
        m_req = 1; m_pend = 1;
      end
      m_flag = t_flag | t_set;
      m_sd = phase_strobe;
      m_pd = ext_pin;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_tag, " call_req"}, int'(call_req), int'(m_req));
      chk({cur_tag, " call_vec"}, int'(call_vec), m_vec);
      chk({cur_tag, " flags"},    int'(flag_o),   int'(m_flag));
      chk({cur_tag, " enables"},  int'(enable_o), int'(m_en));
      chk({cur_tag, " gie"},      int'(gie_o),    int'(m_gie));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; tick(); reg_we = 0;
  endtask

  task automatic strobe(input string tag, input int exp_req);
    phase_strobe = 1; tick();
    chk({tag, " call issued"}, int'(call_req), exp_req);
    phase_strobe = 0; tick();
  endtask

  task automatic ack(); call_ack = 1; tick(); call_ack = 0; endtask

  task automatic evt(input logic [3:0] m); hw_evt = m; tick(); hw_evt = '0; endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    cur_tag = "R1";
    chk("R1 call_req", int'(call_req), 0);
    chk("R1 call_vec", int'(call_vec), 0);
    chk("R1 flags", int'(flag_o), 0);
    chk("R1 enables", int'(enable_o), 0);
    chk("R1 gie", int'(gie_o), 0);

    // R10 register write port
    cur_tag = "R10";
    wr(2'd1, 5'h1F); chk("R10 enables", int'(enable_o), 'h1F);
    wr(2'd3, 5'h15);
    chk("R10 addr3 flags", int'(flag_o), 0);
    chk("R10 addr3 enables", int'(enable_o), 'h1F);
    chk("R10 addr3 gie", int'(gie_o), 0);
    wr(2'd0, 5'h0A); chk("R10 flags", int'(flag_o), 'h0A);
    wr(2'd0, 5'h00);

    // R2 edge modes and internal events
    cur_tag = "R2";
    ext_edge_mode = 2'b01;
    ext_pin = 1; tick(); chk("R2 rise mode rise", int'(flag_o), 'h01);
    wr(2'd0, 0);
    ext_pin = 0; tick(); chk("R2 rise mode fall", int'(flag_o), 0);
    ext_edge_mode = 2'b10;
    ext_pin = 1; tick(); chk("R2 fall mode rise", int'(flag_o), 0);
    ext_pin = 0; tick(); chk("R2 fall mode fall", int'(flag_o), 'h01);
    wr(2'd0, 0);
    ext_edge_mode = 2'b00;
    ext_pin = 1; tick(); ext_pin = 0; tick();
    chk("R2 off mode", int'(flag_o), 0);
    ext_edge_mode = 2'b11;
    ext_pin = 1; tick(); chk("R2 both mode rise", int'(flag_o), 'h01);
    wr(2'd0, 0);
    ext_pin = 0; tick(); chk("R2 both mode fall", int'(flag_o), 'h01);
    ext_edge_mode = 2'b00;
    wr(2'd0, 0);
    evt(4'b0101); chk("R2 internal events", int'(flag_o), 'h0A);
    wr(2'd0, 0);

    // R6 global and per-source masking
    cur_tag = "R6";
    wr(2'd0, 5'h10);
    strobe("R6 gie off", 0);
    chk("R6 flag latched", int'(flag_o), 'h10);
    wr(2'd1, 5'h0F); wr(2'd2, 5'h01);
    strobe("R6 source off", 0);
    chk("R6 flag still latched", int'(flag_o), 'h10);
    wr(2'd1, 5'h1F);
    strobe("R6 enabled", 1);
    chk("R5 time base vector", int'(call_vec), 'h14);
    cur_tag = "R9";
    ack();
    chk("R9 flag cleared", int'(flag_o), 0);
    chk("R9 gie cleared", int'(gie_o), 0);

    // R4/R5/R8 priority order
    cur_tag = "R4";
    wr(2'd0, 5'h1F); wr(2'd2, 5'h01);
    strobe("R4 all pending", 1);
    chk("R4 external first", int'(call_vec), 'h04);
    cur_tag = "R8";
    strobe("R8 no call while outstanding", 0);
    chk("R5 vector held", int'(call_vec), 'h04);
    call_ack = 1; tick(); call_ack = 0;
    chk("R9 others kept", int'(flag_o), 'h1E);
    cur_tag = "R4";
    for (int k = 1; k < 5; k++) begin
      wr(2'd2, 5'h01);
      strobe("R4 next source", 1);
      chk("R4 order vector", int'(call_vec), (k + 1) * 4);
      ack();
    end
    chk("R4 all served", int'(flag_o), 0);
    cur_tag = "R8";
    ack(); chk("R8 stray ack ignored gie", int'(gie_o), 0);

    // R7 stack full
    cur_tag = "R7";
    wr(2'd0, 5'h04); wr(2'd2, 5'h01);
    stack_full = 1;
    strobe("R7 stack full", 0);
    stack_full = 0;
    strobe("R7 stack free", 1);
    chk("R7 timer1 vector", int'(call_vec), 'h0C);
    ack();

    // R3 event coinciding with strobe rise waits; held strobe arbitrates once
    cur_tag = "R3";
    wr(2'd2, 5'h01);
    phase_strobe = 1; hw_evt = 4'b0100; tick();
    chk("R3 same-cycle event deferred", int'(call_req), 0);
    hw_evt = 0; phase_strobe = 0; tick();
    chk("R3 flag latched", int'(flag_o), 'h08);
    strobe("R3 later rise", 1);
    chk("R3 A/D vector", int'(call_vec), 'h10);
    ack();
    wr(2'd0, 5'h03); wr(2'd2, 5'h01);
    phase_strobe = 1; tick();
    chk("R3 held strobe first call", int'(call_req), 1);
    ack(); wr(2'd2, 5'h01); tick();
    chk("R3 held strobe no repeat", int'(call_req), 0);
    phase_strobe = 0; tick();
    strobe("R3 new rise", 1);
    chk("R3 timer0 vector", int'(call_vec), 'h08);
    ack();

    // R11 hardware set wins
    cur_tag = "R11";
    wr(2'd0, 0);
    reg_we = 1; reg_addr = 2'd0; reg_wdata = 0; hw_evt = 4'b0001; tick();
    reg_we = 0; hw_evt = 0;
    chk("R11 set beats sw clear", int'(flag_o), 'h02);
    wr(2'd2, 5'h01);
    strobe("R11 call", 1);
    call_ack = 1; hw_evt = 4'b0001; tick(); call_ack = 0; hw_evt = 0;
    chk("R11 set beats ack clear", int'(flag_o), 'h02);
    chk("R9 gie cleared on ack", int'(gie_o), 0);
    wr(2'd0, 0);
    tick();
    finish_run();
  end

endmodule